// File: doc/BRIEF.md
# Ready/Busy Status Reporter

This block tells the outside world whether the memory array is still being programmed. A dedicated ready/busy pin follows the programming sequencer's busy flag at all times, whatever the chip select is doing. When the host opens a selection with the serial clock held low, the block also puts the same ready/busy level on the shared serial data output. This lets a host poll for completion over its normal serial lines, with no clock pulses needed.

The status phase lasts until the host deselects, or until it clocks in a 1 on the data input, which is the start bit of a new opcode. When the device is ready and the session is healthy, that start bit is passed to the command front end as a one-cycle frame-start pulse. The block also drives a lockout that rejects new instructions in two cases: while programming is in progress, and when the host did not keep chip select high for the minimum deselect time before selecting again.

All inputs are already synchronised to the system clock. Serial clock edges are found by comparing each sample with the previous one.

Top module: `rdy_status_reporter`

## Requirements
- R1: `rdy_pin` is 0 while `prog_busy` is 1 and 1 otherwise, regardless of `cs_n` and of any session state.
- R2: If `cs_n` falls (1 then 0 on consecutive samples) while `sclk` is 0 and the deselect gap was long enough, status mode starts one clock later. In status mode `sdo_oe` is 1 and `sdo` gives the live ready state: 1 means ready, 0 means busy.
- R3: `sdo_oe` is 0 in every cycle in which `cs_n` is 1, without waiting for a clock edge. Deselecting ends status mode.
- R4: A rising `sclk` edge with `sdi` at 1 ends status mode, and `sdo_oe` is 0 from the next clock. Rising edges with `sdi` at 0 leave status mode unchanged. With no `sclk` edges at all, status mode holds for as long as the device stays selected.
- R5: While selected, `lockout` is 1 whenever `prog_busy` is 1. Once busy has been seen during a selection, `lockout` stays 1 until `cs_n` rises. While deselected, `lockout` is 0.
- R6: When status mode ends on a start bit, `frame_start` is 1 for exactly one clock, one clock after the edge is sampled. This happens only if the session is not locked and `prog_busy` is 0. In every other case `frame_start` stays 0.
- R7: A selection that follows fewer than `MIN_DESEL_CYC` consecutive samples of `cs_n` at 1 is rejected. `lockout` is 1 from the next clock until deselection, and status mode is not entered. A gap of exactly `MIN_DESEL_CYC` samples is accepted.
- R8: A selection that starts while `sclk` is 1 never enters status mode, so `sdo_oe` and `frame_start` stay 0 for that whole selection.
- R9: After reset, `sdo_oe`, `sdo`, `lockout` and `frame_start` are 0, and the first selection is accepted without any deselect gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_busy | input | 1 | Programming in progress, from the sequencer |
| cs_n | input | 1 | Synchronised chip select, active low |
| sclk | input | 1 | Synchronised serial clock level |
| sdi | input | 1 | Synchronised serial data input |
| rdy_pin | output | 1 | Dedicated ready/busy level, 1 = ready |
| sdo | output | 1 | Status bit for the shared data output |
| sdo_oe | output | 1 | Drive enable for the shared data output |
| lockout | output | 1 | Rejects the current instruction |
| frame_start | output | 1 | One-cycle start-bit hand-off to the command front end |

## Verification
The bench builds the block with `MIN_DESEL_CYC` = 6 instead of the default of 63. This puts the accept/reject boundary of the deselect gap only a few cycles away. Directed steps hit a gap of exactly 6 samples and a gap of 5. Random sessions with gaps from 1 to 10 then cross that boundary many times, combined with random busy levels, random serial clock levels at selection, and random start-bit patterns.

// File: rtl/rdy_status_reporter.sv
module rdy_status_reporter #(
  parameter int MIN_DESEL_CYC = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_busy,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic rdy_pin,
  output logic sdo,
  output logic sdo_oe,
  output logic lockout,
  output logic frame_start
);
  localparam int CW = $clog2(MIN_DESEL_CYC + 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(MIN_DESEL_CYC);

  logic          cs_q, sclk_q, stat_q, reject_q, start_q;
  logic [CW-1:0] gap_q;

  wire cs_fall   = cs_q & ~cs_n;
  wire gap_ok    = gap_q >= GAP_MAX;
  wire sk_rise   = sclk & ~sclk_q;
  wire start_bit = stat_q & ~cs_n & sk_rise & sdi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      stat_q   <= 1'b0;
      reject_q <= 1'b0;
      start_q  <= 1'b0;
      gap_q    <= GAP_MAX;
    end else begin
      cs_q    <= cs_n;
      sclk_q  <= sclk;
      start_q <= start_bit & ~prog_busy & ~reject_q;
      if (cs_n) begin
        gap_q    <= gap_ok ? gap_q : gap_q + 1'b1;
        stat_q   <= 1'b0;
        reject_q <= 1'b0;
      end else begin
        gap_q    <= '0;
        reject_q <= reject_q | prog_busy | (cs_fall & ~gap_ok);
        if (cs_fall)        stat_q <= ~sclk & gap_ok;
        else if (start_bit) stat_q <= 1'b0;
      end
    end
  end

  assign rdy_pin     = ~prog_busy;
  assign sdo_oe      = stat_q & ~cs_n;
  assign sdo         = sdo_oe & ~prog_busy;
  assign lockout     = ~cs_n & (reject_q | prog_busy);
  assign frame_start = start_q;

  p_exit_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !cs_n && sclk && !sclk_q && sdi) |=> !sdo_oe);

  p_no_handoff_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |=> !frame_start);

  p_desel_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!stat_q && !reject_q));

  p_short_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && !cs_n && !gap_ok) |=> (cs_n || (lockout && !sdo_oe)));

  p_handoff_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: tb/rdy_status_reporter_test.sv
module rdy_status_reporter_test;
  localparam int GAP = 6;
  logic clk = 1'b0, rst_n = 1'b0, prog_busy = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic rdy_pin, sdo, sdo_oe, lockout, frame_start;
  int total = 0, fails = 0;
  bit done = 1'b0;

  rdy_status_reporter #(.MIN_DESEL_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .rdy_pin(rdy_pin), .sdo(sdo), .sdo_oe(sdo_oe), .lockout(lockout), .frame_start(frame_start));

  always #2 clk = ~clk;

  function automatic bit exp_accept(int gap_len);
    return gap_len >= GAP;
  endfunction

  function automatic bit exp_status(bit accepted, bit sk_at_fall);
    return accepted & ~sk_at_fall;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic deselect(int n);
    @(negedge clk);
    cs_n = 1'b1;
    #1 chk("R3 oe off at deselect", sdo_oe, 1'b0);
    chk("R5 no lockout when deselected", lockout, 1'b0);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_select(bit sk);
    sclk = sk;
    cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(bit d, bit exp_fs, string req);
    sdi = d;
    sclk = 1'b1;
    @(negedge clk);
    chk(req, frame_start, exp_fs);
    sclk = 1'b0;
    @(negedge clk);
    chk("R6 pulse one cycle", frame_start, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h1F2E);
    repeat (3) @(negedge clk);
    chk("R9 oe after reset", sdo_oe, 1'b0);
    chk("R9 sdo after reset", sdo, 1'b0);
    chk("R9 lockout after reset", lockout, 1'b0);
    chk("R9 frame_start after reset", frame_start, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    do_select(1'b0);
    chk("R9 first select accepted", sdo_oe, 1'b1);
    chk("R2 ready shown as 1", sdo, 1'b1);
    repeat (50) @(negedge clk);
    chk("R4 status holds without clocks", sdo_oe, 1'b1);
    prog_busy = 1'b1;
    #1 chk("R2 busy shown live", sdo, 1'b0);
    chk("R1 rdy low while busy", rdy_pin, 1'b0);
    chk("R5 lockout while busy", lockout, 1'b1);
    @(negedge clk);
    prog_busy = 1'b0;
    #1 chk("R5 lockout sticks to session", lockout, 1'b1);
    pulse(1'b0, 1'b0, "R4 zero bit keeps status");
    chk("R4 status kept after 0 bit", sdo_oe, 1'b1);
    pulse(1'b1, 1'b0, "R6 no hand-off in locked session");
    chk("R4 status ends on 1 bit", sdo_oe, 1'b0);

    deselect(GAP);
    prog_busy = 1'b1;
    #1 chk("R1 rdy low while deselected", rdy_pin, 1'b0);
    prog_busy = 1'b0;
    do_select(1'b0);
    chk("R7 exact gap accepted", sdo_oe, 1'b1);
    chk("R7 exact gap not locked", lockout, 1'b0);
    pulse(1'b1, 1'b1, "R6 hand-off when ready");
    chk("R4 status ends on start bit", sdo_oe, 1'b0);

    deselect(GAP - 1);
    do_select(1'b0);
    chk("R7 short gap no status", sdo_oe, 1'b0);
    chk("R7 short gap locked", lockout, 1'b1);

    deselect(GAP + 2);
    do_select(1'b1);
    chk("R8 sclk high no status", sdo_oe, 1'b0);
    sclk = 1'b0;
    @(negedge clk);
    pulse(1'b1, 1'b0, "R8 no hand-off outside status");

    for (int it = 0; it < 300; it++) begin
      int  g = 1 + ($urandom % 10);
      bit  bz = ($urandom % 4) == 0;
      bit  sk = $urandom % 2;
      int  np = $urandom % 4;
      bit  acc, st, lk;
      deselect(g);
      prog_busy = bz;
      #1 chk("R1 rdy follows busy", rdy_pin, ~bz);
      acc = exp_accept(g);
      st  = exp_status(acc, sk);
      lk  = ~acc | bz;
      do_select(sk);
      chk("R2 status entry", sdo_oe, st);
      chk("R2 status level", sdo, st & ~bz);
      chk("R5 R7 lockout", lockout, lk);
      if (sk) begin sclk = 1'b0; @(negedge clk); end
      for (int p = 0; p < np; p++) begin
        bit d = $urandom % 2;
        pulse(d, st & d & ~lk, "R6 random hand-off");
        if (d) st = 1'b0;
        chk("R4 status after bit", sdo_oe, st);
      end
      prog_busy = 1'b0;
    end
    deselect(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule